// File: doc/BRIEF.md
# Quarter-word multiply-accumulate unit

This unit performs multiply-accumulate steps on wide words. An operation starts with a one-cycle `start` pulse. On that pulse the unit takes one 64-bit quarter from each of two 256-bit source operands. It multiplies the two quarters as unsigned numbers and moves the 128-bit product up by a whole number of quarters. It then adds the result to a 256-bit accumulator that the unit holds internally. If asked, the unit first treats the accumulator as zero. The result is written back in one of three ways:

- Accumulator only: the sum goes to the accumulator and nothing else is written.
- Full write-out: the sum goes to the accumulator and also to the destination register.
- Shift-out: the low half of the sum is merged into one half of the destination, and the accumulator keeps only the high half.

The multiply is not done in one cycle. A 64-bit by `DIGIT_W`-bit partial-product step is reused over several cycles. The caller watches `busy` and takes the write-back from a one-cycle `done` pulse. The destination register file stays outside the unit. The caller gives the destination's current value at start, so that a half-word merge can be formed. A side port lets the caller load the accumulator while the unit is idle and read it at any time.

Top module: `qmac_unit`

## Requirements
- R1: After reset the accumulator reads 0, and `busy`, `done` and `dst_we` are low.
- R2: Quarter k of an operand is bits [64k+63:64k], with k taken from its own 2-bit select. The two chosen quarters are multiplied as unsigned 64-bit numbers into a 128-bit product.
- R3: The 2-bit shift code s moves the product left by 64*s bits, so the shift is 0, 64, 128 or 192. The shifted value is added to the accumulator and the sum is cut to its low 256 bits.
- R4: When `zero_acc` is high at start, the old accumulator value is taken as zero in the sum.
- R5: Mode code 0 (accumulate only) puts the sum in the accumulator, and `dst_we` stays low at `done`. Code 3 behaves the same way.
- R6: Mode code 1 (full write-out) raises `dst_we` with `dst_wdata` equal to the sum, and the accumulator also takes the sum.
- R7: Mode code 2 (shift-out) raises `dst_we`. The sum's low 128 bits go to the upper half of `dst_wdata` if `half_sel` is 1, or to the lower half if it is 0. The other half equals the same half of `dst_old` as sampled at start. The accumulator takes the sum shifted right by 128 bits.
- R8: A start while idle raises `busy` on the next edge. Exactly STEPS = 64/DIGIT_W edges after the start edge, `done` (and `dst_we` where the mode writes) is high for one cycle and `busy` is low.
- R9: A `start` while `busy` is ignored. The running operation finishes with its own operands.
- R10: `acc_wr_en` while idle loads `acc_wr_data` into the accumulator on that edge. While busy it has no effect. `acc_rd_data` always shows the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| src_a | input | WORD_W | First source operand |
| src_b | input | WORD_W | Second source operand |
| qsel_a | input | 2 | Quarter select for `src_a` |
| qsel_b | input | 2 | Quarter select for `src_b` |
| shift_code | input | 2 | Product shift in quarters |
| zero_acc | input | 1 | Treat accumulator as zero for this operation |
| mode | input | 2 | Write-back mode: 0 acc only, 1 full, 2 shift-out, 3 acc only |
| half_sel | input | 1 | Destination half for shift-out (1 = upper) |
| dst_old | input | WORD_W | Current destination value, used for merging |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dst_we | output | 1 | Destination write enable, valid with `done` |
| dst_wdata | output | WORD_W | Destination write data |
| acc_wr_en | input | 1 | Side-port accumulator load |
| acc_wr_data | input | WORD_W | Side-port load value |
| acc_rd_data | output | WORD_W | Current accumulator value |

## Verification
The accumulator is read back at `done` after every operation. Because of this, a wrong partial product, a wrong quarter choice or a wrong shift makes the result differ in that same cycle. A wrong carry into the accumulator shows up in the very next accumulating operation. The sweep covers every pair of quarter selects with every shift code, so a mis-indexed slice cannot hide behind a lucky operand value. A step counter that is off by one moves `done` by a cycle, and the bench samples that cycle exactly. A shift-out that merges into the wrong half, or that leaves low bits in the accumulator, shows on `dst_wdata` and `acc_rd_data` at the same `done` pulse.

// File: rtl/qmac_pkg.sv
package qmac_pkg;
    typedef enum logic [1:0] {
        WB_ACC   = 2'd0,
        WB_FULL  = 2'd1,
        WB_SPLIT = 2'd2,
        WB_SPARE = 2'd3
    } wb_mode_e;
endpackage

// File: rtl/qmac_qsel.sv
module qmac_qsel #(
    parameter int WORD_W = 256,
    parameter int QUART  = WORD_W / 4
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        sel_i,
    output logic [QUART-1:0]  part_o
);
    always_comb begin
        part_o = word_i[int'(sel_i)*QUART +: QUART];
    end
endmodule

// File: rtl/qmac_mul_step.sv
module qmac_mul_step #(
    parameter int QUART   = 64,
    parameter int DIGIT_W = 16
) (
    input  logic [2*QUART-1:0] prod_i,
    input  logic [QUART-1:0]   mcand_i,
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [2*QUART-1:0] prod_o
);
    localparam int SUM_W = QUART + DIGIT_W + 1;

    logic [SUM_W-1:0]       upper;
    logic [SUM_W+QUART-1:0] joined;

    always_comb begin
        upper  = SUM_W'(prod_i[2*QUART-1:QUART]) + SUM_W'(mcand_i) * SUM_W'(digit_i);
        joined = {upper, prod_i[QUART-1:0]};
        prod_o = joined[DIGIT_W +: 2*QUART];
    end
endmodule

// File: rtl/qmac_wb.sv
module qmac_wb
    import qmac_pkg::*;
#(
    parameter int WORD_W = 256,
    parameter int QUART  = WORD_W / 4
) (
    input  logic [WORD_W-1:0]  acc_i,
    input  logic [2*QUART-1:0] prod_i,
    input  logic [1:0]         shift_i,
    input  logic               zero_i,
    input  wb_mode_e           mode_i,
    input  logic               half_i,
    input  logic [WORD_W-1:0]  old_i,
    output logic [WORD_W-1:0]  acc_o,
    output logic               we_o,
    output logic [WORD_W-1:0]  wdata_o
);
    localparam int HALF = WORD_W / 2;

    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] sum;

    always_comb begin
        shifted = WORD_W'(prod_i) << (int'(shift_i) * QUART);
        sum     = (zero_i ? '0 : acc_i) + shifted;
        acc_o   = sum;
        we_o    = 1'b0;
        wdata_o = '0;
        unique case (mode_i)
            WB_FULL: begin
                we_o    = 1'b1;
                wdata_o = sum;
            end
            WB_SPLIT: begin
                we_o    = 1'b1;
                acc_o   = WORD_W'(sum[WORD_W-1:HALF]);
                wdata_o = half_i ? {sum[HALF-1:0], old_i[HALF-1:0]}
                                 : {old_i[WORD_W-1:HALF], sum[HALF-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/qmac_unit.sv
module qmac_unit
    import qmac_pkg::*;
#(
    parameter int WORD_W  = 256,
    parameter int DIGIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    input  logic [1:0]        qsel_a,
    input  logic [1:0]        qsel_b,
    input  logic [1:0]        shift_code,
    input  logic              zero_acc,
    input  logic [1:0]        mode,
    input  logic              half_sel,
    input  logic [WORD_W-1:0] dst_old,
    output logic              busy,
    output logic              done,
    output logic              dst_we,
    output logic [WORD_W-1:0] dst_wdata,
    input  logic              acc_wr_en,
    input  logic [WORD_W-1:0] acc_wr_data,
    output logic [WORD_W-1:0] acc_rd_data
);
    localparam int QUART  = WORD_W / 4;
    localparam int HALF   = WORD_W / 2;
    localparam int PROD_W = 2 * QUART;
    localparam int STEPS  = QUART / DIGIT_W;
    localparam int CNT_W  = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [QUART-1:0]  mcand;
        logic [QUART-1:0]  mplier;
        logic [PROD_W-1:0] prod;
        logic [1:0]        shift;
        logic              zero;
        wb_mode_e          mode;
        logic              half;
        logic [WORD_W-1:0] old;
        logic [WORD_W-1:0] acc;
        logic              done;
        logic              we;
        logic [WORD_W-1:0] wdata;
    } st_t;

    localparam st_t ST_RST = '0;

    st_t st_d, st_q;

    logic [QUART-1:0]  quart_a, quart_b;
    logic [PROD_W-1:0] step_prod;
    logic [WORD_W-1:0] wb_acc, wb_wdata;
    logic              wb_we;

    qmac_qsel #(.WORD_W(WORD_W), .QUART(QUART)) u_sel_a (
        .word_i(src_a), .sel_i(qsel_a), .part_o(quart_a));
    qmac_qsel #(.WORD_W(WORD_W), .QUART(QUART)) u_sel_b (
        .word_i(src_b), .sel_i(qsel_b), .part_o(quart_b));

    qmac_mul_step #(.QUART(QUART), .DIGIT_W(DIGIT_W)) u_step (
        .prod_i (st_q.prod),
        .mcand_i(st_q.mcand),
        .digit_i(st_q.mplier[DIGIT_W-1:0]),
        .prod_o (step_prod)
    );

    qmac_wb #(.WORD_W(WORD_W), .QUART(QUART)) u_wb (
        .acc_i  (st_q.acc),
        .prod_i (step_prod),
        .shift_i(st_q.shift),
        .zero_i (st_q.zero),
        .mode_i (st_q.mode),
        .half_i (st_q.half),
        .old_i  (st_q.old),
        .acc_o  (wb_acc),
        .we_o   (wb_we),
        .wdata_o(wb_wdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.we   = 1'b0;
        if (!st_q.busy) begin
            if (acc_wr_en) begin
                st_d.acc = acc_wr_data;
            end
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.cnt    = '0;
                st_d.mcand  = quart_a;
                st_d.mplier = quart_b;
                st_d.prod   = '0;
                st_d.shift  = shift_code;
                st_d.zero   = zero_acc;
                st_d.mode   = wb_mode_e'(mode);
                st_d.half   = half_sel;
                st_d.old    = dst_old;
            end
        end else begin
            st_d.prod   = step_prod;
            st_d.mplier = st_q.mplier >> DIGIT_W;
            st_d.cnt    = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(STEPS - 1)) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.acc   = wb_acc;
                st_d.we    = wb_we;
                st_d.wdata = wb_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign busy        = st_q.busy;
    assign done        = st_q.done;
    assign dst_we      = st_q.we;
    assign dst_wdata   = st_q.wdata;
    assign acc_rd_data = st_q.acc;

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(st_q.busy) && !st_q.busy);  // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);  // R8
    AST_WE_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.we |-> st_q.done);  // R5
    AST_ACC_ONLY_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && (st_q.mode == WB_ACC || st_q.mode == WB_SPARE)) |-> !st_q.we);  // R5
    AST_SPLIT_ACC_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.mode == WB_SPLIT) |-> (st_q.acc[WORD_W-1:HALF] == '0));  // R7
    AST_SPLIT_KEEPS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.mode == WB_SPLIT) |->
        (st_q.half ? (st_q.wdata[HALF-1:0] == st_q.old[HALF-1:0])
                   : (st_q.wdata[WORD_W-1:HALF] == st_q.old[WORD_W-1:HALF])));  // R7
    AST_ACC_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.busy) && !st_q.done) |-> $stable(st_q.acc));  // R10
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.busy) && st_q.busy) |-> $stable(st_q.mode) && $stable(st_q.old));  // R9
endmodule

// File: tb/sim_qmac_unit.sv
module sim_qmac_unit;
    localparam int WORD_W  = 256;
    localparam int DIGIT_W = 16;
    localparam int STEPS   = 64 / DIGIT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [WORD_W-1:0] src_a = '0, src_b = '0, dst_old = '0, acc_wr_data = '0;
    logic [1:0]        qsel_a = '0, qsel_b = '0, shift_code = '0, mode = '0;
    logic              zero_acc = 1'b0, half_sel = 1'b0, acc_wr_en = 1'b0;
    logic              busy, done, dst_we;
    logic [WORD_W-1:0] dst_wdata, acc_rd_data;

    int checks = 0;
    int errors = 0;
    logic [WORD_W-1:0] acc_m = '0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    qmac_unit #(.WORD_W(WORD_W), .DIGIT_W(DIGIT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
        .qsel_a(qsel_a), .qsel_b(qsel_b), .shift_code(shift_code), .zero_acc(zero_acc),
        .mode(mode), .half_sel(half_sel), .dst_old(dst_old), .busy(busy), .done(done),
        .dst_we(dst_we), .dst_wdata(dst_wdata), .acc_wr_en(acc_wr_en),
        .acc_wr_data(acc_wr_data), .acc_rd_data(acc_rd_data));

    task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] rnd256();
        logic [WORD_W-1:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Drives one operation and checks timing and results against a model.
    task automatic do_op(input logic [WORD_W-1:0] a, b, input logic [1:0] sa, sb, sh,
                         input logic z, input logic [1:0] md, input logic hs,
                         input logic [WORD_W-1:0] old, input bit disturb, input string req);
        logic [63:0]       qa, qb;
        logic [127:0]      prod;
        logic [WORD_W-1:0] sum, exp_w, exp_acc;
        logic              exp_we;
        qa   = a[int'(sa)*64 +: 64];
        qb   = b[int'(sb)*64 +: 64];
        prod = {64'b0, qa} * {64'b0, qb};
        sum  = (z ? '0 : acc_m) + ({128'b0, prod} << (int'(sh) * 64));
        exp_we = 1'b0; exp_w = '0; exp_acc = sum;
        if (md == 2'd1) begin
            exp_we = 1'b1; exp_w = sum;
        end else if (md == 2'd2) begin
            exp_we  = 1'b1;
            exp_w   = hs ? {sum[127:0], old[127:0]} : {old[255:128], sum[127:0]};
            exp_acc = {128'b0, sum[255:128]};
        end
        src_a = a; src_b = b; qsel_a = sa; qsel_b = sb; shift_code = sh;
        zero_acc = z; mode = md; half_sel = hs; dst_old = old; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 busy after start", {255'b0, busy}, 1);
        if (disturb) begin
            // R9 / R10: new start and side write while busy must be ignored
            src_a = ~a; src_b = ~b; mode = 2'd1; dst_old = ~old; zero_acc = ~z;
            start = 1'b1; acc_wr_en = 1'b1; acc_wr_data = ~acc_m;
        end
        repeat (STEPS - 1) @(negedge clk);
        start = 1'b0; acc_wr_en = 1'b0;
        chk("R8 not done early", {255'b0, done}, 0);
        @(negedge clk);
        chk("R8 done pulse", {255'b0, done}, 1);
        chk("R8 busy clear", {255'b0, busy}, 0);
        chk({req, " we"}, {255'b0, dst_we}, {255'b0, exp_we});
        if (exp_we) chk({req, " wdata"}, dst_wdata, exp_w);
        chk({req, " acc"}, acc_rd_data, exp_acc);
        acc_m = exp_acc;
        @(negedge clk);
        chk("R8 done one cycle", {255'b0, done}, 0);
        chk("R9 no restart", {255'b0, busy}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 acc reset", acc_rd_data, '0);
        chk("R1 busy reset", {255'b0, busy}, 0);
        chk("R1 done/we reset", {254'b0, done, dst_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R6: every select pair with every shift code, full write-out
        for (int sa = 0; sa < 4; sa++)
            for (int sb = 0; sb < 4; sb++)
                for (int sh = 0; sh < 4; sh++)
                    do_op(rnd256(), rnd256(), 2'(sa), 2'(sb), 2'(sh), ((sa + sb + sh) % 3) == 0,
                          2'd1, 1'b0, '0, 1'b0, "R2 R3 R6 full");

        // R3 truncation: all-ones quarters at the largest shift onto a full accumulator
        do_op('1, '1, 2'd3, 2'd3, 2'd3, 1'b0, 2'd1, 1'b0, '0, 1'b0, "R3 trunc");

        // R4 zero-accumulate discards a nonzero accumulator
        do_op(rnd256(), rnd256(), 2'd1, 2'd2, 2'd0, 1'b1, 2'd1, 1'b0, '0, 1'b0, "R4 zero");

        // R5 accumulate-only, codes 0 and 3
        do_op(rnd256(), rnd256(), 2'd0, 2'd3, 2'd1, 1'b0, 2'd0, 1'b0, '0, 1'b0, "R5 acc");
        do_op(rnd256(), rnd256(), 2'd2, 2'd1, 2'd2, 1'b0, 2'd3, 1'b0, '0, 1'b0, "R5 spare");

        // R7 shift-out into both halves
        for (int k = 0; k < 8; k++)
            do_op(rnd256(), rnd256(), 2'(k), 2'(k + 1), 2'(k >> 1), k == 0, 2'd2, k[0],
                  rnd256(), 1'b0, "R7 split");

        // R9 R10 disturbance while busy
        do_op(rnd256(), rnd256(), 2'd1, 2'd0, 2'd1, 1'b0, 2'd2, 1'b1, rnd256(), 1'b1, "R9 R10 busy");
        do_op(rnd256(), rnd256(), 2'd3, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0, '0, 1'b1, "R9 R10 busy");

        // R10 side-port load while idle, then used by the next accumulation
        acc_wr_data = rnd256(); acc_wr_en = 1'b1;
        @(negedge clk);
        acc_wr_en = 1'b0;
        acc_m = acc_wr_data;
        chk("R10 side load", acc_rd_data, acc_m);
        do_op(rnd256(), rnd256(), 2'd0, 2'd0, 2'd2, 1'b0, 2'd1, 1'b0, '0, 1'b0, "R10 use");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule